// File: doc/BRIEF.md
# Shared Core Memory Controller

This block sequences access to one core memory array that up to four processor buses share. Each bus raises a cycle request together with read and/or write request flags and an address. The controller picks one requester, latches that bus's address and flags, and answers with a one-cycle address acknowledge. A read gets the stored word on the bus's return data lines, marked by a one-cycle read-restart pulse. A write gets nothing more until the bus shows a rising edge on its write-restart line with the data. Core readout is destructive, so a read-only cycle writes the word back before the module is freed. A read-and-write cycle discards the read copy and stores the data that comes with the write restart.

The bus handshake is made of pulses, not a valid/ready stream, and there is no back-pressure at the edge. A bus holds its request until it sees its own acknowledge and should then drop it. A write restart is taken only from the bus that owns the cycle and only once the acknowledge cycle has passed. Other buses wait as long as a cycle is open. Ports 0 and 1 have fixed rank. Ports 2 and 3 share the lowest rank and take turns.

Top module: `core_mem_ctrl`

## Requirements
- R1: A port counts as requesting only when `cyc_rq` is high together with at least one of `rd_rq` or `wr_rq`. A bare `cyc_rq` is never acknowledged.
- R2: When the module is free, port 0 is granted over every other port, and port 1 is granted over ports 2 and 3.
- R3: When ports 2 and 3 request together and ports 0 and 1 do not, the one of the two that was granted less recently wins. After reset, port 3 wins the first such tie.
- R4: From grant until the cycle completes, no other port is acknowledged, and write-restart edges from other ports have no effect on the stored data.
- R5: `addr_ack` goes high for exactly one clock, on the granted port only, in the clock after the edge that samples the request. After reset it stays low until a request arrives.
- R6: For a cycle with `rd_rq` set, `rd_rs` of the granted port is high in the same clock as `addr_ack`, and `rd_data` of that port carries the stored word. In every other clock, `rd_data` is all zero.
- R7: A read-only cycle writes the word it read back to the same location, so later reads return the same value, and it frees the module by itself.
- R8: A read-and-write cycle returns the old word with the acknowledge. It then stores `wr_data` of the owner, taken on the first rising edge of that port's `wr_rs`.
- R9: A write-only cycle keeps the module busy until the owner's `wr_rs` rises, and then stores that port's `wr_data`.
- R10: A read-only cycle takes two clocks. A request still pending when it completes is granted in the next clock, so back-to-back acknowledges are two clocks apart.
- R11: Only the low `ARRAY_AW` address bits select the word. Addresses that differ only above them reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_rq | input | 4 | Per-port memory cycle request level |
| rd_rq | input | 4 | Per-port read request flag |
| wr_rq | input | 4 | Per-port write request flag |
| addr_in | input | 4 x ADDR_W | Per-port word address |
| wr_data | input | 4 x DATA_W | Per-port write data, sampled on the write-restart edge |
| wr_rs | input | 4 | Per-port write restart; its rising edge commits a write |
| addr_ack | output | 4 | Per-port one-clock address acknowledge |
| rd_rs | output | 4 | Per-port one-clock read restart |
| rd_data | output | 4 x DATA_W | Per-port read data, non-zero only with read restart |

## Verification
The bench builds the controller with a 14-bit address, 36-bit words and `ARRAY_AW` set to 6. This makes a 64-word array that can be filled completely, so every later read has a known expected value. With this setting, random 14-bit addresses alias heavily, which exercises the low-bit word selection and the write-back of read-only cycles on shared words. It also makes the tie between ports 2 and 3 easy to set up repeatedly from reset.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int unsigned NPORTS = 4;
  localparam int unsigned PORT_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_WAIT = 2'd2
  } ccm_state_e;
endpackage

// File: rtl/ccm_arbiter.sv
module ccm_arbiter
  import ccm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] req,
  input  logic              take,
  output logic              gnt_vld,
  output logic [PORT_W-1:0] gnt_idx
);
  // high when port 3 was the later of ports 2/3 to be served
  logic hi_last_q;

  always_comb begin
    gnt_vld = |req;
    gnt_idx = '0;
    if (req[0])               gnt_idx = 2'd0;
    else if (req[1])          gnt_idx = 2'd1;
    else if (req[2] && req[3]) gnt_idx = hi_last_q ? 2'd2 : 2'd3;
    else if (req[2])          gnt_idx = 2'd2;
    else if (req[3])          gnt_idx = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       hi_last_q <= 1'b0;
    else if (take && gnt_idx[1])      hi_last_q <= gnt_idx[0];
  end

  assert_gnt_is_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> req[gnt_idx]);
  assert_port0_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> (gnt_idx == 2'd0));
  assert_port1_rank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req[1] && !req[0]) |-> (gnt_idx == 2'd1));
endmodule

// File: rtl/ccm_array.sv
module ccm_array #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/ccm_port_if.sv
module ccm_port_if #(
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rs_in,
  input  logic          owner,
  input  logic          ack_p,
  input  logic          rs_p,
  input  logic [DW-1:0] word_i,
  output logic          edge_o,
  output logic          ack_o,
  output logic          rs_o,
  output logic [DW-1:0] rd_data_o
);
  logic rs_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rs_prev_q <= 1'b0;
    else        rs_prev_q <= rs_in;
  end

  assign edge_o    = rs_in & ~rs_prev_q;
  assign ack_o     = ack_p & owner;
  assign rs_o      = rs_p & owner;
  assign rd_data_o = rs_o ? word_i : '0;

  assert_rs_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_o |-> ack_o);
  assert_data_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o != '0) |-> rs_o);
endmodule

// File: rtl/core_mem_ctrl.sv
module core_mem_ctrl
  import ccm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned DATA_W   = 36,
  parameter int unsigned ARRAY_AW = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORTS-1:0]             cyc_rq,
  input  logic [NPORTS-1:0]             rd_rq,
  input  logic [NPORTS-1:0]             wr_rq,
  input  logic [NPORTS-1:0][ADDR_W-1:0] addr_in,
  input  logic [NPORTS-1:0][DATA_W-1:0] wr_data,
  input  logic [NPORTS-1:0]             wr_rs,
  output logic [NPORTS-1:0]             addr_ack,
  output logic [NPORTS-1:0]             rd_rs,
  output logic [NPORTS-1:0][DATA_W-1:0] rd_data
);
  ccm_state_e          state_q;
  logic [PORT_W-1:0]   act_q;
  logic [ARRAY_AW-1:0] loc_q;
  logic                rd_f_q, wr_f_q;
  logic [DATA_W-1:0]   word_q;
  logic                ack_p_q, rs_p_q;

  logic [NPORTS-1:0]   req_v;
  logic [NPORTS-1:0]   edge_v;
  logic                gnt_vld;
  logic [PORT_W-1:0]   gnt_idx;
  logic                take;
  logic                own_edge;
  logic                arr_we;
  logic [DATA_W-1:0]   arr_wd;
  logic [DATA_W-1:0]   arr_q;
  logic                unused_addr;

  assign unused_addr = ^addr_in;

  always_comb begin
    for (int i = 0; i < NPORTS; i++) req_v[i] = cyc_rq[i] & (rd_rq[i] | wr_rq[i]);
  end

  assign take = (state_q == ST_IDLE) && gnt_vld;

  ccm_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_v),
    .take    (take),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  ccm_array #(.AW(ARRAY_AW), .DW(DATA_W)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr (loc_q),
    .wdata (arr_wd),
    .raddr (addr_in[gnt_idx][ARRAY_AW-1:0]),
    .rdata (arr_q)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    ccm_port_if #(.DW(DATA_W)) u_pif (
      .clk       (clk),
      .rst_n     (rst_n),
      .rs_in     (wr_rs[p]),
      .owner     (act_q == PORT_W'(p)),
      .ack_p     (ack_p_q),
      .rs_p      (rs_p_q),
      .word_i    (word_q),
      .edge_o    (edge_v[p]),
      .ack_o     (addr_ack[p]),
      .rs_o      (rd_rs[p]),
      .rd_data_o (rd_data[p])
    );
  end

  assign own_edge = edge_v[act_q];
  assign arr_we   = ((state_q == ST_ACK) && rd_f_q && !wr_f_q) ||
                    ((state_q == ST_WAIT) && own_edge);
  assign arr_wd   = (state_q == ST_WAIT) ? (word_q | wr_data[act_q]) : word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      loc_q   <= '0;
      rd_f_q  <= 1'b0;
      wr_f_q  <= 1'b0;
      word_q  <= '0;
      ack_p_q <= 1'b0;
      rs_p_q  <= 1'b0;
    end else begin
      ack_p_q <= 1'b0;
      rs_p_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (gnt_vld) begin
            act_q   <= gnt_idx;
            loc_q   <= addr_in[gnt_idx][ARRAY_AW-1:0];
            rd_f_q  <= rd_rq[gnt_idx];
            wr_f_q  <= wr_rq[gnt_idx];
            word_q  <= rd_rq[gnt_idx] ? arr_q : '0;
            ack_p_q <= 1'b1;
            rs_p_q  <= rd_rq[gnt_idx];
            state_q <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (rd_f_q && !wr_f_q) begin
            state_q <= ST_IDLE;
          end else begin
            word_q  <= '0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (own_edge) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_ack));
  assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ack != '0) |=> (addr_ack == '0));
  assert_owner_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> $stable(act_q));
  assert_no_ack_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (addr_ack == '0));
  assert_wait_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && !own_edge) |=> (state_q == ST_WAIT));
  assert_rdonly_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ACK) && rd_f_q && !wr_f_q) |=> (state_q == ST_IDLE));
endmodule

// File: tb/sim_core_mem_ctrl.sv
module sim_core_mem_ctrl;
  import ccm_pkg::*;
  localparam int AW = 14;
  localparam int DW = 36;
  localparam int MAW = 6;
  localparam int DEPTH = 1 << MAW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPORTS-1:0]         cyc_rq = '0, rd_rq = '0, wr_rq = '0, wr_rs = '0;
  logic [NPORTS-1:0][AW-1:0] addr_in = '0;
  logic [NPORTS-1:0][DW-1:0] wr_data = '0;
  logic [NPORTS-1:0]         addr_ack, rd_rs;
  logic [NPORTS-1:0][DW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int last23 = 2;
  longint cyc = 0;
  logic [DW-1:0] model [DEPTH];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  core_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ARRAY_AW(MAW)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_rq(cyc_rq), .rd_rq(rd_rq), .wr_rq(wr_rq),
    .addr_in(addr_in), .wr_data(wr_data), .wr_rs(wr_rs),
    .addr_ack(addr_ack), .rd_rs(rd_rs), .rd_data(rd_data)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pick(input logic [3:0] m, input int last);
    if (m[0]) return 0;
    if (m[1]) return 1;
    if (m[2] && m[3]) return (last == 2) ? 3 : 2;
    if (m[2]) return 2;
    if (m[3]) return 3;
    return -1;
  endfunction

  task automatic wait_ack(output int g);
    int k = 0;
    g = -1;
    while (addr_ack == '0 && k < 60) begin
      @(negedge clk);
      k++;
    end
    for (int i = 0; i < NPORTS; i++) if (addr_ack[i] && g < 0) g = i;
  endtask

  // kind: 0 read-only, 1 read-and-write, 2 write-only
  task automatic txn(input int p, input logic [AW-1:0] a, input int kind,
                     input logic [DW-1:0] wd, input string tag);
    int g;
    int idx = int'(a) % DEPTH;
    logic [DW-1:0] exp;
    @(negedge clk);
    cyc_rq[p] = 1'b1; rd_rq[p] = (kind != 2); wr_rq[p] = (kind != 0); addr_in[p] = a;
    wait_ack(g);
    check("R5", "acknowledged port", g, p);
    if (g == p) begin
      exp = (kind == 2) ? '0 : model[idx];
      check("R6", "read restart", rd_rs[p], kind != 2);
      check(tag, "returned word", rd_data[p], exp);
    end
    if (p >= 2) last23 = p;
    cyc_rq[p] = 1'b0; rd_rq[p] = 1'b0; wr_rq[p] = 1'b0;
    @(negedge clk);
    check("R5", "ack width", addr_ack, 0);
    check("R6", "data quiet", rd_data[p], 0);
    if (kind != 0) begin
      wr_data[p] = wd; wr_rs[p] = 1'b1;
      @(negedge clk);
      wr_rs[p] = 1'b0;
      model[idx] = wd;
    end
  endtask

  task automatic serve_set(input logic [3:0] mask);
    logic [3:0] m = mask;
    int g, e;
    longint prev = -1;
    string tag;
    @(negedge clk);
    for (int i = 0; i < NPORTS; i++)
      if (m[i]) begin cyc_rq[i] = 1'b1; rd_rq[i] = 1'b1; addr_in[i] = AW'(i); end
    while (m != 0) begin
      e = pick(m, last23);
      tag = (m[2] && m[3] && !m[1] && !m[0]) ? "R3" : "R2";
      wait_ack(g);
      check(tag, "grant order", g, e);
      if (g < 0) begin
        m = 0;
      end else begin
        check("R6", "set read word", rd_data[g], model[g]);
        if (prev >= 0) check("R10", "ack spacing", cyc - prev, 2);
        prev = cyc;
        if (g >= 2) last23 = g;
        cyc_rq[g] = 1'b0; rd_rq[g] = 1'b0; m[g] = 1'b0;
        @(negedge clk);
      end
    end
    cyc_rq = '0; rd_rq = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int g;
    int p, kind;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5", "reset ack", addr_ack, 0);
    check("R6", "reset rd_rs", rd_rs, 0);
    check("R6", "reset data", rd_data[0], 0);

    // R1: request without read or write flag is not served
    @(negedge clk);
    cyc_rq[2] = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R1", "bare request ack", addr_ack, 0);
    end
    cyc_rq[2] = 1'b0;

    // fill the array through port 0
    for (int i = 0; i < DEPTH; i++)
      txn(0, AW'(i), 2, DW'(36'h5A5000000 + i * 36'h10001), "R9");

    // R3 tie right after reset favours port 3, then alternation
    serve_set(4'b1100);
    serve_set(4'b1100);
    serve_set(4'b1111);
    serve_set(4'b1110);
    serve_set(4'b0110);

    // R7: read-only twice returns same word
    txn(1, 14'd9, 0, '0, "R7");
    txn(2, 14'd9, 0, '0, "R7");
    // R8: read-and-write returns old, stores new
    txn(3, 14'd11, 1, 36'hFEDCBA987, "R8");
    txn(0, 14'd11, 0, '0, "R8");
    // R11: aliasing above the low address bits
    txn(1, 14'd5, 2, 36'h123456789, "R9");
    txn(2, 14'd5 + 14'd192, 0, '0, "R11");
    txn(0, 14'h3FC5, 0, '0, "R11");

    // R4/R9: write-only cycle on port 3 holds the module
    @(negedge clk);
    cyc_rq[3] = 1'b1; wr_rq[3] = 1'b1; addr_in[3] = 14'd7;
    wait_ack(g);
    check("R9", "write-only ack port", g, 3);
    last23 = 3;
    cyc_rq[3] = 1'b0; wr_rq[3] = 1'b0;
    @(negedge clk);
    cyc_rq[0] = 1'b1; rd_rq[0] = 1'b1; addr_in[0] = 14'd7;
    wr_data[1] = 36'hBADBADBAD; wr_rs[1] = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      wr_rs[1] = 1'b0;
      check("R4", "ack while busy", addr_ack, 0);
    end
    wr_data[3] = 36'h0C0FFEE11; wr_rs[3] = 1'b1;
    @(negedge clk);
    wr_rs[3] = 1'b0;
    model[7] = 36'h0C0FFEE11;
    wait_ack(g);
    check("R4", "waiting port served", g, 0);
    check("R9", "committed word", rd_data[0], 36'h0C0FFEE11);
    cyc_rq[0] = 1'b0; rd_rq[0] = 1'b0;
    @(negedge clk);

    // constrained random traffic
    for (int n = 0; n < 250; n++) begin
      p = int'($urandom % 4);
      kind = int'($urandom % 3);
      a = AW'($urandom);
      d = {4'($urandom), 32'($urandom)};
      txn(p, a, kind, d, (kind == 0) ? "R7" : ((kind == 1) ? "R8" : "R9"));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule